// File: doc/BRIEF.md
# ATA command block sequencer

This block takes a 16-byte command block, one byte per cycle on a valid/ready stream, and checks its length, its identifying bytes and its control byte. When the block passes, it drives a single-cycle register-access port towards an ATA taskfile. It can first wait for the device to leave its busy state, and it then writes the device/head register and the command register in an order that the command selects. After that it supervises a data phase, which it ends either when the data side reports completion or when an error arrives that the command's halt policy treats as fatal.

The configuration that would normally come from a serial memory is modelled as static inputs: the expected first byte and a default drive-select bit. The block reports each finished command with a one-cycle done pulse and a set of status flags. Each flag holds until the first byte of the next block arrives. It also presents the transfer mode (PIO or UDMA) and an IDENTIFY-data marker for the data engine.

Top module: `ata_cb_sequencer`

## Requirements
- R1: A block is accepted for execution only if the final byte (marked by `cb_last`) is byte index 15. Shorter and longer blocks set `st_rejected` and pulse `cmd_done` one cycle after the final byte is taken.
- R2: Byte 0 must equal `cfg_signature` and byte 1 must equal 0x24. Otherwise the block is rejected. `st_accepted` and `st_rejected` are never both high.
- R3: The control byte is byte 2. If its bit 0 (taskfile read-back request) is set and its bits 4:3 are not 00, the block is rejected.
- R4: When control bit 2 is 0, the block reads the alternate status register (address 0xE, read) and repeats the read until bit 7 of the returned data is 0. Only then does it make any write. When control bit 2 is 1, no read is made.
- R5: If POLL_LIMIT (default 4) reads in a row return bit 7 set, the block stops polling, sets `st_timeout`, pulses `cmd_done` and makes no write.
- R6: When control bit 1 is 0, the device/head write (address 0x6) comes before the command write (address 0x7). When control bit 1 is 1, the command write comes first.
- R7: The device/head write carries byte 11, with its bit 4 replaced by the DEV value. DEV is `cfg_dev` when control bit 5 is 0, and bit 4 of byte 11 when control bit 5 is 1. The command write carries byte 12.
- R8: In the data phase, a device error halts unless control bit 4 is 1, and a phase error halts unless control bit 3 is 1. Policy 00 halts on either error, 01 on a device error only, 10 on a phase error only, and 11 on neither.
- R9: A halting error sampled at a clock edge drops `dp_run` in the next cycle, sets `st_halted` and pulses `cmd_done`. A non-halting error leaves `dp_run` high and the status unchanged.
- R10: `dp_end` ends the data phase with a `cmd_done` pulse and `st_accepted` high. `xfer_udma` equals control bit 6 and `xfer_identify` equals control bit 7 of the accepted block.
- R11: `cb_ready` is low from the final byte until the command finishes, and no taskfile access is made while it is high. A rejected block makes no taskfile access. Status flags clear when the next block's first byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_signature | input | 8 | Required value of byte 0 |
| cfg_dev | input | 1 | Default DEV bit |
| cb_valid | input | 1 | Command byte valid |
| cb_data | input | 8 | Command byte |
| cb_last | input | 1 | Final byte of the block |
| cb_ready | output | 1 | Block can take a byte |
| tf_req | output | 1 | Taskfile access request |
| tf_we | output | 1 | 1 = write, 0 = read |
| tf_addr | output | 4 | Taskfile register address |
| tf_wdata | output | 8 | Write data |
| tf_ack | input | 1 | Access completes this cycle |
| tf_rdata | input | 8 | Read data |
| dp_run | output | 1 | Data accesses allowed |
| dp_end | input | 1 | Data phase complete |
| dev_err | input | 1 | Device error seen |
| phase_err | input | 1 | Phase error seen |
| cmd_done | output | 1 | One-cycle pulse at the end of a command |
| st_accepted | output | 1 | Block passed checks |
| st_rejected | output | 1 | Block failed checks |
| st_timeout | output | 1 | Busy polling gave up |
| st_halted | output | 1 | Data phase halted by an error |
| xfer_udma | output | 1 | UDMA transfer mode |
| xfer_identify | output | 1 | Data phase carries IDENTIFY data |

## Verification
A wrong byte counter or a wrong stored control byte shows up at the taskfile port within the same command. It appears as an extra or missing status read, writes in the wrong order, or a wrong bit 4 in the device/head value, and the bench compares every access against its expected list as it happens. A wrong halt decision shows on `dp_run` and `st_halted` one cycle after the injected error. A stuck state shows as `cb_ready` never returning, which the bench bounds with its per-command wait limit.

// File: rtl/ata_cb_sequencer.sv
module ata_cb_sequencer #(
  parameter int         BLOCK_LEN   = 16,
  parameter int         POLL_LIMIT  = 4,
  parameter logic [7:0] SUBCMD      = 8'h24,
  parameter logic [3:0] REG_DEVHEAD = 4'h6,
  parameter logic [3:0] REG_COMMAND = 4'h7,
  parameter logic [3:0] REG_ALTSTAT = 4'hE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg_signature,
  input  logic       cfg_dev,
  input  logic       cb_valid,
  input  logic [7:0] cb_data,
  input  logic       cb_last,
  output logic       cb_ready,
  output logic       tf_req,
  output logic       tf_we,
  output logic [3:0] tf_addr,
  output logic [7:0] tf_wdata,
  input  logic       tf_ack,
  input  logic [7:0] tf_rdata,
  output logic       dp_run,
  input  logic       dp_end,
  input  logic       dev_err,
  input  logic       phase_err,
  output logic       cmd_done,
  output logic       st_accepted,
  output logic       st_rejected,
  output logic       st_timeout,
  output logic       st_halted,
  output logic       xfer_udma,
  output logic       xfer_identify
);

  localparam int IW = $clog2(BLOCK_LEN + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(BLOCK_LEN - 1);
  localparam logic [IW-1:0] IDX_SIG  = IW'(0);
  localparam logic [IW-1:0] IDX_SUB  = IW'(1);
  localparam logic [IW-1:0] IDX_ACT  = IW'(2);
  localparam logic [IW-1:0] IDX_DH   = IW'(11);
  localparam logic [IW-1:0] IDX_CMD  = IW'(12);

  typedef enum logic [2:0] {S_IDLE, S_POLL, S_WR1, S_WR2, S_DATA} state_t;
  state_t state;

  logic [IW-1:0] idx;
  logic [PW-1:0] polls;
  logic [7:0]    sig_b, sub_b, act_b, dh_b, cmd_b;

  wire take     = cb_valid && cb_ready;
  wire len_ok   = idx == LAST_IDX;
  wire id_ok    = (sig_b == cfg_signature) && (sub_b == SUBCMD);
  wire combo_ok = !(act_b[0] && (act_b[4:3] != 2'b00));
  wire accept   = len_ok && id_ok && combo_ok;
  wire dev_bit  = act_b[5] ? dh_b[4] : cfg_dev;
  wire [7:0] devhead_val = {dh_b[7:5], dev_bit, dh_b[3:0]};
  wire sel_first = !act_b[1];
  wire halt_now  = (dev_err && !act_b[4]) || (phase_err && !act_b[3]);
  wire first_wr_dh = (state == S_WR1) == sel_first;

  assign cb_ready = (state == S_IDLE);
  assign tf_req   = (state == S_POLL) || (state == S_WR1) || (state == S_WR2);
  assign tf_we    = (state == S_WR1) || (state == S_WR2);
  assign tf_addr  = (state == S_POLL) ? REG_ALTSTAT : (first_wr_dh ? REG_DEVHEAD : REG_COMMAND);
  assign tf_wdata = (state == S_POLL) ? 8'h00 : (first_wr_dh ? devhead_val : cmd_b);
  assign dp_run   = (state == S_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      sig_b <= '0;
      sub_b <= '0;
      act_b <= '0;
      dh_b  <= '0;
      cmd_b <= '0;
    end else if (take) begin
      if (cb_last) idx <= '0;
      else if (idx != IW'(BLOCK_LEN)) idx <= idx + 1'b1;
      case (idx)
        IDX_SIG: sig_b <= cb_data;
        IDX_SUB: sub_b <= cb_data;
        IDX_ACT: act_b <= cb_data;
        IDX_DH:  dh_b  <= cb_data;
        IDX_CMD: cmd_b <= cb_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      polls         <= '0;
      cmd_done      <= 1'b0;
      st_accepted   <= 1'b0;
      st_rejected   <= 1'b0;
      st_timeout    <= 1'b0;
      st_halted     <= 1'b0;
      xfer_udma     <= 1'b0;
      xfer_identify <= 1'b0;
    end else begin
      cmd_done <= 1'b0;
      case (state)
        S_IDLE: if (take) begin
          if (idx == '0) begin
            st_accepted <= 1'b0;
            st_rejected <= 1'b0;
            st_timeout  <= 1'b0;
            st_halted   <= 1'b0;
          end
          if (cb_last) begin
            if (accept) begin
              st_accepted   <= 1'b1;
              xfer_udma     <= act_b[6];
              xfer_identify <= act_b[7];
              polls         <= '0;
              state         <= act_b[2] ? S_WR1 : S_POLL;
            end else begin
              st_rejected <= 1'b1;
              cmd_done    <= 1'b1;
            end
          end
        end
        S_POLL: if (tf_ack) begin
          if (!tf_rdata[7]) state <= S_WR1;
          else if (polls == PW'(POLL_LIMIT - 1)) begin
            st_timeout <= 1'b1;
            cmd_done   <= 1'b1;
            state      <= S_IDLE;
          end else polls <= polls + 1'b1;
        end
        S_WR1: if (tf_ack) state <= S_WR2;
        S_WR2: if (tf_ack) state <= S_DATA;
        S_DATA: begin
          if (halt_now) begin
            st_halted <= 1'b1;
            cmd_done  <= 1'b1;
            state     <= S_IDLE;
          end else if (dp_end) begin
            cmd_done <= 1'b1;
            state    <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_NO_TF_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cb_ready |-> !tf_req); // R11
  AST_DONE_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done); // R10
  AST_HALT_STOPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_run && halt_now) |=> (!dp_run && st_halted && cmd_done)); // R9
  AST_SAFE_ERR_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_run && !halt_now && !dp_end) |=> dp_run); // R9
  AST_TIMEOUT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    st_timeout |-> !tf_req); // R5
  AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_accepted, st_rejected})); // R2
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    st_rejected |-> cb_ready); // R11

endmodule

// File: tb/ata_cb_sequencer_tb.sv
module ata_cb_sequencer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_signature = 8'h5A;
  logic cfg_dev = 1'b0;
  logic cb_valid = 1'b0, cb_last = 1'b0;
  logic [7:0] cb_data = 8'h00;
  logic cb_ready, tf_req, tf_we, dp_run, cmd_done;
  logic [3:0] tf_addr;
  logic [7:0] tf_wdata, tf_rdata;
  logic tf_ack = 1'b1;
  logic dp_end = 1'b0, dev_err = 1'b0, phase_err = 1'b0;
  logic st_accepted, st_rejected, st_timeout, st_halted, xfer_udma, xfer_identify;

  int tests = 0, fails = 0, cyc = 0, busy_left = 0;
  logic [12:0] expq[$];
  logic [7:0]  blk[$];

  always #2.5 clk = ~clk;

  ata_cb_sequencer u_dut (.*);

  assign tf_rdata = (busy_left > 0) ? 8'h80 : 8'h50;
  always @(posedge clk) if (tf_req && !tf_we && tf_ack && busy_left > 0) busy_left <= busy_left - 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && tf_req) begin
    logic [12:0] got, want;
    got = {tf_we, tf_addr, tf_we ? tf_wdata : 8'h00};
    if (expq.size() == 0) check("R11 unexpected taskfile access", 32'(got), 32'h1FFF);
    else begin
      want = expq.pop_front();
      check("R4/R6/R7 taskfile access", 32'(got), 32'(want));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic build(input logic [7:0] sig, sub, act, dh, cmd, input int len);
    blk.delete();
    for (int i = 0; i < len; i++)
      blk.push_back(i == 0 ? sig : i == 1 ? sub : i == 2 ? act : i == 11 ? dh : i == 12 ? cmd : 8'(i));
  endtask

  task automatic send();
    for (int i = 0; i < blk.size(); i++) begin
      @(negedge clk);
      while (!cb_ready) @(negedge clk);
      cb_valid = 1'b1; cb_data = blk[i]; cb_last = (i == blk.size() - 1);
      @(posedge clk);
    end
    @(negedge clk);
    cb_valid = 1'b0; cb_last = 1'b0;
  endtask

  task automatic wait_phase(output bit in_data);
    int n = 0;
    while (!dp_run && !cmd_done && n < 100) begin @(negedge clk); n++; end
    in_data = dp_run;
  endtask

  task automatic push_rd(int n);
    for (int i = 0; i < n; i++) expq.push_back({1'b0, 4'hE, 8'h00});
  endtask

  // runs an accepted command to its data phase, then ends it with dp_end
  task automatic run_ok(string tag, bit udma, bit ident);
    bit d;
    send();
    wait_phase(d);
    check({tag, " data phase reached"}, 32'(d), 1);
    check("R11 ready low while busy", 32'(cb_ready), 0);
    check("R10 udma flag", 32'(xfer_udma), 32'(udma));
    check("R10 identify flag", 32'(xfer_identify), 32'(ident));
    dp_end = 1'b1; @(negedge clk); dp_end = 1'b0;
    check("R10 done pulse", 32'({cmd_done, st_accepted, dp_run, cb_ready}), 32'b1101);
    check({tag, " expected accesses consumed"}, 32'(expq.size()), 0);
  endtask

  task automatic run_reject(string tag);
    send();
    check({tag, " reject verdict"}, 32'({cmd_done, st_rejected, st_accepted, cb_ready}), 32'b1101);
    @(negedge clk);
    check({tag, " no access after reject"}, 32'({tf_req, cmd_done}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset outputs", 32'({cb_ready, tf_req, dp_run, cmd_done, st_accepted, st_rejected, st_timeout, st_halted}), 32'b1000_0000);
    rst_n = 1'b1;

    // R4 polling with two busy reads, R6 device/head first, R7 DEV from cfg (0)
    busy_left = 2;
    build(8'h5A, 8'h24, 8'b0100_0000, 8'hE5, 8'hEC, 16);
    push_rd(3);
    expq.push_back({1'b1, 4'h6, 8'hE5 & 8'hEF});
    expq.push_back({1'b1, 4'h7, 8'hEC});
    run_ok("R4", 1'b1, 1'b0);

    // R4 skip polling, R6 command first, R7 DEV from byte 11 bit 4 (1)
    busy_left = 3;
    build(8'h5A, 8'h24, 8'b1010_0110, 8'h10, 8'hA1, 16);
    expq.push_back({1'b1, 4'h7, 8'hA1});
    expq.push_back({1'b1, 4'h6, 8'h10});
    run_ok("R6", 1'b0, 1'b1);
    busy_left = 0;

    // R7 DEV from cfg_dev=1 with byte 11 bit 4 clear
    cfg_dev = 1'b1;
    build(8'h5A, 8'h24, 8'b0000_0100, 8'hA0, 8'h25, 16);
    expq.push_back({1'b1, 4'h6, 8'hB0});
    expq.push_back({1'b1, 4'h7, 8'h25});
    run_ok("R7", 1'b0, 1'b0);
    cfg_dev = 1'b0;

    // R2 bad signature / bad subcommand
    build(8'h5B, 8'h24, 8'h04, 8'h00, 8'h00, 16); run_reject("R2 signature");
    build(8'h5A, 8'h25, 8'h04, 8'h00, 8'h00, 16); run_reject("R2 subcommand");
    // R1 short and long
    build(8'h5A, 8'h24, 8'h04, 8'h00, 8'h00, 15); run_reject("R1 short");
    build(8'h5A, 8'h24, 8'h04, 8'h00, 8'h00, 17); run_reject("R1 long");
    // R3 read-back with override bits
    build(8'h5A, 8'h24, 8'b0000_1101, 8'h00, 8'h00, 16); run_reject("R3 readback+override");
    // R3 read-back alone is fine; R11 status cleared by new block
    build(8'h5A, 8'h24, 8'b0000_0101, 8'h00, 8'h30, 16);
    expq.push_back({1'b1, 4'h6, 8'h00});
    expq.push_back({1'b1, 4'h7, 8'h30});
    run_ok("R3", 1'b0, 1'b0);
    check("R11 reject flag cleared", 32'(st_rejected), 0);

    // R5 timeout
    busy_left = 1000;
    build(8'h5A, 8'h24, 8'b0000_0000, 8'h00, 8'h30, 16);
    push_rd(4);
    begin
      bit d;
      send();
      wait_phase(d);
      check("R5 timeout verdict", 32'({d, cmd_done, st_timeout, cb_ready}), 32'b0111);
      @(negedge clk);
      check("R5 no write after timeout", 32'({tf_req, expq.size() == 0}), 32'b01);
    end
    busy_left = 0;

    // R8/R9 halt policies with each error type
    for (int pol = 0; pol < 4; pol++) begin
      for (int et = 0; et < 2; et++) begin
        bit d, halts;
        halts = (et == 0) ? !pol[1] : !pol[0];
        build(8'h5A, 8'h24, {3'b000, 2'(pol), 3'b100}, 8'h00, 8'h30, 16);
        expq.push_back({1'b1, 4'h6, 8'h00});
        expq.push_back({1'b1, 4'h7, 8'h30});
        send();
        wait_phase(d);
        check("R8 data phase reached", 32'(d), 1);
        if (et == 0) dev_err = 1'b1; else phase_err = 1'b1;
        @(negedge clk);
        dev_err = 1'b0; phase_err = 1'b0;
        check($sformatf("R8 policy %0d err %0d", pol, et), 32'({dp_run, st_halted, cmd_done}),
              halts ? 32'b011 : 32'b100);
        if (!halts) begin
          dp_end = 1'b1; @(negedge clk); dp_end = 1'b0;
          check("R9 safe error then end", 32'({cmd_done, st_halted, dp_run}), 32'b100);
        end
      end
    end

    repeat (3) @(negedge clk);
    check("R11 final idle", 32'({cb_ready, tf_req, dp_run}), 32'b100);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule